// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesizer Core

This block is the digital core of a direct digital frequency synthesizer. A tuning word presented with a load strobe is held in a frequency register. Every clock, a phase accumulator adds that word to a phase register, which wraps modulo 2^ACC_W. The upper bits of the phase address a sine amplitude table, and the registered signed sample goes to an external converter. The output frequency is f_clk * tuning_word / 2^ACC_W.

The accumulator adder is built from fixed-width blocks. Inside each block the carry ripples. When every bit of a block propagates, the block's incoming carry skips straight to its outgoing carry. This keeps the worst-case carry path shorter than a full ripple chain.

A new tuning word takes effect without clearing the phase, so frequency switches are phase-continuous. The default configuration is a 16-bit accumulator, 4-bit skip blocks, an 8-bit table address and 10-bit signed samples.

Top module: `ddfs_core`

## Requirements
- R1: While `rst` is high at a clock edge, the frequency word, the phase and `amp_out` all become zero. `amp_out` stays zero until a nonzero word has been loaded.
- R2: When `fcw_load` is high at a clock edge, `fcw_in` is captured at that edge. From the next edge on, the phase grows by the captured word on every edge.
- R3: The phase wraps modulo 2^ACC_W. A sum that overflows keeps only its low ACC_W bits.
- R4: `amp_out` is registered. After edge e it shows the table value for the phase held just before edge e.
- R5: The table address is the top ADDR_W phase bits. Let H = 2^(ADDR_W-1), let k be the address modulo H, and let P = k*(H-k). The magnitude is floor(AMAX*16*P / (5*H*H - 4*P)), where AMAX = 2^(AMP_W-1)-1. The sample is that magnitude when the address MSB is 0, and its two's-complement negative when the MSB is 1.
- R6: Loading a new word never changes the phase held at that moment, so switching frequency is phase-continuous.
- R7: The adder returns {carry_out, sum} = a + b + carry_in for all operands. It uses blocks of BLK bits, and a fully propagating block passes its carry-in directly to its carry-out.
- R8: While `fcw_load` is low, `fcw_in` has no effect, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw_load | input | 1 | Capture strobe for the tuning word |
| fcw_in | input | ACC_W (16) | Frequency tuning word |
| amp_out | output | AMP_W (10) | Signed sine amplitude sample |

## Verification
The adder is swept exhaustively on an 8-bit, two-block instance. This covers every operand pair with both carry-in values, so block-skip faults are told apart from ripple faults.

The full core is driven with several tuning words:
- A word equal to one address step visits every table entry in order, which isolates table contents and sign folding.
- An all-ones word walks the phase backwards through constant wraparound.
- Block-patterned words such as 0x0F0F and 0xF0F1 exercise skip and no-skip carries across block edges.

Reloads in mid-run test phase continuity. A toggling word with the strobe low shows that unloaded inputs are ignored.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

    localparam int ACC_W   = 16;
    localparam int BLK_W   = 4;
    localparam int ADDR_W  = 8;
    localparam int AMP_W   = 10;

    localparam int HALF    = 2 ** (ADDR_W - 1);
    localparam int QTR     = HALF / 2;
    localparam int AMP_MAX = 2 ** (AMP_W - 1) - 1;

    typedef logic [ACC_W-1:0]         phase_t;
    typedef logic [ADDR_W-1:0]        lut_addr_t;
    typedef logic signed [AMP_W-1:0]  amp_t;

    typedef struct packed {
        phase_t freq;
        phase_t phase;
    } acc_state_t;

    // Rational sine approximation over a half period of HALF steps
    function automatic amp_t half_sine_mag(int k);
        int prod;
        int num;
        int den;
        prod = k * (HALF - k);
        num  = AMP_MAX * 16 * prod;
        den  = 5 * HALF * HALF - 4 * prod;
        return amp_t'(num / den);
    endfunction

endpackage

// File: rtl/cskip_adder.sv
module cskip_adder #(
    parameter int W   = 16,
    parameter int BLK = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NBLK = W / BLK;

    logic [NBLK:0] bcarry;
    assign bcarry[0] = cin;

    for (genvar bi = 0; bi < NBLK; bi++) begin : g_blk
        logic [BLK-1:0] p;
        logic [BLK-1:0] g;
        logic [BLK:0]   rc;
        assign p     = a[bi*BLK +: BLK] ^ b[bi*BLK +: BLK];
        assign g     = a[bi*BLK +: BLK] & b[bi*BLK +: BLK];
        assign rc[0] = bcarry[bi];
        for (genvar i = 0; i < BLK; i++) begin : g_bit
            assign rc[i+1]          = g[i] | (p[i] & rc[i]);
            assign sum[bi*BLK + i]  = p[i] ^ rc[i];
        end
        // block bypass: a fully propagating block forwards its carry-in
        assign bcarry[bi+1] = (&p) ? bcarry[bi] : rc[BLK];
    end

    assign cout = bcarry[NBLK];

    always_comb begin
        assert_sum_exact_R7: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("carry-skip sum mismatch");
    end

endmodule

// File: rtl/ddfs_phase_accum.sv
module ddfs_phase_accum
    import ddfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  phase_t fcw,
    output phase_t phase
);
    acc_state_t st_q;
    acc_state_t st_d;
    phase_t     next_phase;
    logic       carry_out;

    cskip_adder #(.W(ACC_W), .BLK(BLK_W)) u_add (
        .a   (st_q.phase),
        .b   (st_q.freq),
        .cin (1'b0),
        .sum (next_phase),
        .cout(carry_out)
    );

    always_comb begin
        st_d.phase = next_phase;
        st_d.freq  = load ? fcw : st_q.freq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st_q.phase == phase_t'($past(st_q.phase) + $past(st_q.freq)))
        else $error("phase did not advance by frequency word");

    assert_freq_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> st_q.freq == $past(fcw))
        else $error("frequency word not captured");

    assert_freq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.freq))
        else $error("frequency word changed without load");

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        carry_out |=> st_q.phase < $past(st_q.phase))
        else $error("overflow did not wrap phase");

endmodule

// File: rtl/ddfs_sine_lut.sv
module ddfs_sine_lut
    import ddfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lut_addr_t addr,
    output amp_t      amp
);
    localparam int IDX_W = ADDR_W - 1;

    amp_t             qtab [0:QTR];
    logic [IDX_W-1:0] k;
    logic [IDX_W-1:0] fold;
    amp_t             mag;
    amp_t             amp_d;

    for (genvar i = 0; i <= QTR; i++) begin : g_tab
        assign qtab[i] = half_sine_mag(i);
    end

    always_comb begin
        k = addr[IDX_W-1:0];
        if (int'(k) > QTR) begin
            fold = IDX_W'(HALF - int'(k));
        end else begin
            fold = k;
        end
        mag   = qtab[fold];
        amp_d = addr[ADDR_W-1] ? -mag : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp <= '0;
        end else begin
            amp <= amp_d;
        end
    end

    assert_neg_half_R5: assert property (@(posedge clk) disable iff (rst)
        addr[ADDR_W-1] |=> amp <= 0)
        else $error("second half sample not non-positive");

    assert_pos_half_R5: assert property (@(posedge clk) disable iff (rst)
        !addr[ADDR_W-1] |=> amp >= 0)
        else $error("first half sample negative");

endmodule

// File: rtl/ddfs_core.sv
module ddfs_core
    import ddfs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fcw_load,
    input  logic [ACC_W-1:0]        fcw_in,
    output logic signed [AMP_W-1:0] amp_out
);
    phase_t phase;
    amp_t   amp;

    ddfs_phase_accum u_acc (
        .clk  (clk),
        .rst  (rst),
        .load (fcw_load),
        .fcw  (fcw_in),
        .phase(phase)
    );

    ddfs_sine_lut u_lut (
        .clk (clk),
        .rst (rst),
        .addr(phase[ACC_W-1 -: ADDR_W]),
        .amp (amp)
    );

    assign amp_out = amp;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> amp_out == 0)
        else $error("output not cleared by reset");

endmodule

// File: tb/sim_ddfs_core.sv
`timescale 1ns/1ps
module sim_ddfs_core;
    localparam int ACC_W  = 16;
    localparam int ADDR_W = 8;
    localparam int AMP_W  = 10;
    localparam int HALF   = 2 ** (ADDR_W - 1);
    localparam int AMAX   = 2 ** (AMP_W - 1) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    fcw_load = 1'b0;
    logic [ACC_W-1:0]        fcw_in = '0;
    logic signed [AMP_W-1:0] amp_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ddfs_core u0 (
        .clk(clk), .rst(rst), .fcw_load(fcw_load),
        .fcw_in(fcw_in), .amp_out(amp_out)
    );

    // small adder instance for exhaustive sweep
    logic [7:0] ta, tb_b, tsum;
    logic       tcin, tcout;
    cskip_adder #(.W(8), .BLK(4)) u_add8 (
        .a(ta), .b(tb_b), .cin(tcin), .sum(tsum), .cout(tcout)
    );

    function automatic int ref_amp(int addr);
        int k, prod, v;
        k    = addr % HALF;
        prod = k * (HALF - k);
        v    = (AMAX * 16 * prod) / (5 * HALF * HALF - 4 * prod);
        return (addr >= HALF) ? -v : v;
    endfunction

    // arithmetic reference of the register state
    int m_freq  = 0;
    int m_phase = 0;
    int m_amp   = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_freq <= 0; m_phase <= 0; m_amp <= 0;
        end else begin
            m_amp   <= ref_amp(m_phase >> (ACC_W - ADDR_W));
            m_phase <= (m_phase + m_freq) % (2 ** ACC_W);
            if (fcw_load) m_freq <= int'(fcw_in);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, int'(amp_out), m_amp);
        end
    endtask

    task automatic load_word(string req, logic [ACC_W-1:0] w);
        @(negedge clk);
        chk(req, int'(amp_out), m_amp);
        fcw_in   = w;
        fcw_load = 1'b1;
        @(negedge clk);
        chk(req, int'(amp_out), m_amp);
        fcw_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        // R7: exhaustive adder sweep, all operand pairs, both carry-ins
        for (int c = 0; c < 2; c++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    ta = 8'(x); tb_b = 8'(y); tcin = c[0];
                    #1;
                    chk("R7", int'({tcout, tsum}), x + y + c);
                end
            end
        end

        // R1: reset state, and zero output without a load
        repeat (3) @(negedge clk);
        chk("R1", int'(amp_out), 0);
        rst = 1'b0;
        run("R1", 8);
        chk("R1", int'(amp_out), 0);

        // R4: first nonzero sample appears with the registered latency
        load_word("R4", 16'h0100);
        run("R4", 4);

        // R5: step of one address per clock visits every table entry
        run("R5", 2 ** ADDR_W + 4);

        // R3: all-ones word walks backwards through constant wrap
        load_word("R3", 16'hFFFF);
        run("R3", 40);
        load_word("R3", 16'h8001);
        run("R3", 40);

        // R7 in context: block-patterned words across skip boundaries
        load_word("R7", 16'h0F0F);
        run("R7", 120);
        load_word("R7", 16'hF0F1);
        run("R7", 120);

        // R6: mid-run reloads keep the phase continuous
        load_word("R6", 16'h0333);
        run("R6", 7);
        load_word("R6", 16'h1234);
        run("R6", 9);
        load_word("R6", 16'h0A00);
        run("R6", 30);

        // R8: word toggles with strobe low have no effect
        load_word("R2", 16'h0240);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            chk("R8", int'(amp_out), m_amp);
            fcw_in = 16'(i * 16'h1F3B + 16'h5A5A);
        end
        run("R8", 10);

        // R2: capture on the strobe edge, advance from the next edge
        load_word("R2", 16'h0080);
        run("R2", 50);

        // R1: reset mid-run clears output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", int'(amp_out), 0);
        rst = 1'b0;
        run("R1", 5);

        finish_run();
    end

endmodule